// File: doc/BRIEF.md
# Redundancy Status Message Filter

This block sits beside a time-triggered bus controller and watches the frames it decodes in the dynamic part of every communication cycle. One dynamic slot, chosen at run time, carries a fixed two-byte status word for each safety-critical node. The filter takes only the first frame in that slot in each cycle. It unpacks the word and checks the node identity and the unit role against configured values. When the word reports a critical fault, or more consecutive non-critical faults than a programmable limit, it raises a one-clock switchover pulse with no processor in the loop.

After a pulse, the block holds back further pulses until a clear input re-arms it. The decoded fields of the last accepted status word stay visible on output registers. A sticky error flag reports two cases: a status frame in the monitored slot that names the wrong node or the wrong role, and a cycle in which the monitored slot went by with no status frame. Frame decoding, CRC checks and bus timing are done by the controller upstream.

Top module: `failover_status_filter`

## Requirements
- R1: After reset, `trig_pulse`, `err_flag` and every decoded field output are 0.
- R2: A frame is accepted when `frm_valid` is high, `frm_slot` equals `cfg_slot`, the word's node field (bits 15:6) equals `cfg_node`, and its role field (bits 1:0) equals `cfg_role`. The clock edge that samples an accepted frame loads `st_node`, `st_crit` (bit 5), `st_errs` (bits 4:2) and `st_role` from the word.
- R3: A frame in any slot other than `cfg_slot`, or one whose node or role field does not match, leaves the decoded fields unchanged and causes no pulse.
- R4: An accepted frame with bit 5 set gives `trig_pulse` high for exactly the one cycle after the sampling edge, provided the block is armed.
- R5: An accepted frame with bit 5 clear pulses when its error count (bits 4:2) is strictly greater than `cfg_limit`. A count equal to or below the limit does not pulse.
- R6: After a pulse, no further pulse occurs until `trig_clear` has been high for a cycle. The next qualifying frame after that does pulse.
- R7: Within one cycle, as told by the value of `frm_cycle`, only the first frame in the monitored slot is evaluated. Later frames in that slot in the same cycle change nothing.
- R8: The first frame in the monitored slot of a cycle whose node or role field mismatches sets `err_flag`.
- R9: `err_flag` is set when a cycle passes the monitored slot with no frame in it. This shows up either as a frame in a higher slot, or as a frame from a new cycle value when the old cycle never reached the slot. The flag stays set until `trig_clear`.
- R10: `trig_pulse` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe for a received frame |
| frm_slot | input | SLOT_W | Slot number of the frame |
| frm_cycle | input | CYC_W | Communication cycle count of the frame |
| frm_word | input | 16 | First two payload bytes |
| cfg_slot | input | SLOT_W | Monitored slot number (24 in a typical setup) |
| cfg_node | input | 10 | Node identity to match |
| cfg_role | input | 2 | Role code to accept |
| cfg_limit | input | 3 | Consecutive-error limit |
| trig_clear | input | 1 | Re-arms the trigger and clears `err_flag` |
| trig_pulse | output | 1 | One-cycle switchover request |
| st_node | output | 10 | Node field of the last accepted word |
| st_crit | output | 1 | Critical flag of the last accepted word |
| st_errs | output | 3 | Error count of the last accepted word |
| st_role | output | 2 | Role field of the last accepted word |
| err_flag | output | 1 | Sticky mismatch or missing-status flag |

## Verification
The hardest case to reach from the ports is the missing status message that only becomes visible at a cycle boundary. In that case a cycle ends after lower-slot traffic alone, and the fault appears only when a frame from the following cycle arrives. The stimulus keeps its own cycle counter and builds cycles that end early, cycles that skip straight past the slot, and cycles that repeat the monitored slot. This lets the first-frame rule and both missing-slot paths be checked apart from the trigger sweep. The trigger itself is swept over every critical-bit, error-count and limit combination, for several node identities.

// File: rtl/fsf_pkg.sv
`timescale 1ns/1ps
package fsf_pkg;
   localparam int WORD_W = 16;
   localparam int ID_W   = 10;
   localparam int ERR_W  = 3;
   localparam int ROLE_W = 2;

   localparam int ROLE_LSB = 0;
   localparam int ERR_LSB  = ROLE_LSB + ROLE_W;
   localparam int CRIT_POS = ERR_LSB + ERR_W;
   localparam int ID_LSB   = CRIT_POS + 1;
   localparam int USED_W   = ID_LSB + ID_W;

   // status word, most significant field first
   typedef struct packed {
      logic [ID_W-1:0]   node;
      logic              crit;
      logic [ERR_W-1:0]  errs;
      logic [ROLE_W-1:0] role;
   } status_t;

   function automatic status_t unpack_status(input logic [WORD_W-1:0] w);
      status_t s;
      s.node = w[ID_LSB +: ID_W];
      s.crit = w[CRIT_POS];
      s.errs = w[ERR_LSB +: ERR_W];
      s.role = w[ROLE_LSB +: ROLE_W];
      return s;
   endfunction
endpackage

// File: rtl/fsf_decode.sv
`timescale 1ns/1ps
module fsf_decode
   import fsf_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  logic [ID_W-1:0]   own_node,
   input  logic [ROLE_W-1:0] own_role,
   output status_t           fields,
   output logic              id_match
);
   status_t s;

   always_comb begin
      s        = unpack_status(word);
      fields   = s;
      id_match = (s.node == own_node) && (s.role == own_role);
   end
endmodule

// File: rtl/fsf_cycle_track.sv
`timescale 1ns/1ps
module fsf_cycle_track #(
   parameter int SLOT_W = 11,
   parameter int CYC_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [SLOT_W-1:0] slot,
   input  logic [CYC_W-1:0]  cycle,
   input  logic [SLOT_W-1:0] watch_slot,
   input  logic              id_match,
   output logic              accept,
   output logic              reject,
   output logic              missing
);
   logic [CYC_W-1:0] cur_q;
   logic             have_q;
   logic             seen_q;
   logic             new_cyc;
   logic             seen_eff;
   logic             in_slot;
   logic             late;
   logic             first;

   always_comb begin
      new_cyc  = !have_q || (cycle != cur_q);
      seen_eff = new_cyc ? 1'b0 : seen_q;
      in_slot  = (slot == watch_slot);
      late     = (slot > watch_slot);
      first    = valid && in_slot && !seen_eff;
      accept   = first && id_match;
      reject   = first && !id_match;
      missing  = valid && ((new_cyc && have_q && !seen_q) || (late && !seen_eff));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         have_q <= 1'b0;
         seen_q <= 1'b0;
      end else if (valid) begin
         cur_q  <= cycle;
         have_q <= 1'b1;
         seen_q <= seen_eff || in_slot || late;
      end
   end
endmodule

// File: rtl/fsf_trigger.sv
`timescale 1ns/1ps
module fsf_trigger #(
   parameter int ERR_W      = 3,
   parameter bit CMP_STRICT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             crit,
   input  logic [ERR_W-1:0] errs,
   input  logic [ERR_W-1:0] limit,
   input  logic             clear,
   output logic             pulse
);
   logic over;
   logic fire;
   logic fired_q;
   logic pulse_q;

   generate
      if (CMP_STRICT) begin : g_exceed
         assign over = (errs > limit);
      end else begin : g_reach
         assign over = (errs >= limit);
      end
   endgenerate

   assign fire = accept && (crit || over);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         fired_q <= 1'b0;
      end else begin
         pulse_q <= fire && !fired_q;
         fired_q <= (fired_q && !clear) || fire;
      end
   end

   assign pulse = pulse_q;
endmodule

// File: rtl/failover_status_filter.sv
`timescale 1ns/1ps
module failover_status_filter
   import fsf_pkg::*;
#(
   parameter int SLOT_W     = 11,
   parameter int CYC_W      = 6,
   parameter bit CMP_STRICT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic [SLOT_W-1:0] frm_slot,
   input  logic [CYC_W-1:0]  frm_cycle,
   input  logic [15:0]       frm_word,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [9:0]        cfg_node,
   input  logic [1:0]        cfg_role,
   input  logic [2:0]        cfg_limit,
   input  logic              trig_clear,
   output logic              trig_pulse,
   output logic [9:0]        st_node,
   output logic              st_crit,
   output logic [2:0]        st_errs,
   output logic [1:0]        st_role,
   output logic              err_flag
);
   generate
      if (USED_W != WORD_W) begin : g_bad_layout
         $error("status fields do not fill the word");
      end
      if (ID_W != 10 || ERR_W != 3 || ROLE_W != 2) begin : g_bad_ports
         $error("port widths disagree with package field widths");
      end
      if (SLOT_W < 1 || CYC_W < 1) begin : g_bad_width
         $error("slot and cycle widths must be positive");
      end
   endgenerate

   status_t dec;
   status_t held_q;
   logic    id_match;
   logic    accept;
   logic    reject;
   logic    missing;
   logic    err_q;

   fsf_decode u_decode (
      .word     (frm_word),
      .own_node (cfg_node),
      .own_role (cfg_role),
      .fields   (dec),
      .id_match (id_match)
   );

   fsf_cycle_track #(.SLOT_W(SLOT_W), .CYC_W(CYC_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (frm_valid),
      .slot       (frm_slot),
      .cycle      (frm_cycle),
      .watch_slot (cfg_slot),
      .id_match   (id_match),
      .accept     (accept),
      .reject     (reject),
      .missing    (missing)
   );

   fsf_trigger #(.ERR_W(ERR_W), .CMP_STRICT(CMP_STRICT)) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .crit   (dec.crit),
      .errs   (dec.errs),
      .limit  (cfg_limit),
      .clear  (trig_clear),
      .pulse  (trig_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
         err_q  <= 1'b0;
      end else begin
         if (accept) held_q <= dec;
         err_q <= (err_q && !trig_clear) || reject || missing;
      end
   end

   assign st_node  = held_q.node;
   assign st_crit  = held_q.crit;
   assign st_errs  = held_q.errs;
   assign st_role  = held_q.role;
   assign err_flag = err_q;
endmodule

// File: rtl/fsf_checker.sv
`timescale 1ns/1ps
module fsf_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       frm_valid,
   input logic       trig_clear,
   input logic       trig_pulse,
   input logic [9:0] st_node,
   input logic       st_crit,
   input logic [2:0] st_errs,
   input logic [1:0] st_role,
   input logic       err_flag
);
   p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |=> !trig_pulse);

   p_pulse_after_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> $past(frm_valid));

   p_fields_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> ($stable(st_node) && $stable(st_crit) && $stable(st_errs) && $stable(st_role)));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !trig_clear) |=> err_flag);

   p_err_rise_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(frm_valid));
endmodule

bind failover_status_filter fsf_checker u_fsf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_valid  (frm_valid),
   .trig_clear (trig_clear),
   .trig_pulse (trig_pulse),
   .st_node    (st_node),
   .st_crit    (st_crit),
   .st_errs    (st_errs),
   .st_role    (st_role),
   .err_flag   (err_flag)
);

// File: tb/test_failover_status_filter.sv
`timescale 1ns/1ps
module test_failover_status_filter;
   localparam int SLOT_W = 11;
   localparam int CYC_W  = 6;
   localparam int WATCH  = 24;
   localparam logic [1:0] ROLE = 2'b10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frm_valid = 1'b0;
   logic [SLOT_W-1:0] frm_slot = '0;
   logic [CYC_W-1:0]  frm_cycle = '0;
   logic [15:0]       frm_word = '0;
   logic [SLOT_W-1:0] cfg_slot = SLOT_W'(WATCH);
   logic [9:0]        cfg_node = 10'd3;
   logic [1:0]        cfg_role = ROLE;
   logic [2:0]        cfg_limit = 3'd0;
   logic              trig_clear = 1'b0;
   logic              trig_pulse;
   logic [9:0]        st_node;
   logic              st_crit;
   logic [2:0]        st_errs;
   logic [1:0]        st_role;
   logic              err_flag;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   failover_status_filter #(.SLOT_W(SLOT_W), .CYC_W(CYC_W)) i_failover_status_filter (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_slot(frm_slot),
      .frm_cycle(frm_cycle), .frm_word(frm_word), .cfg_slot(cfg_slot),
      .cfg_node(cfg_node), .cfg_role(cfg_role), .cfg_limit(cfg_limit),
      .trig_clear(trig_clear), .trig_pulse(trig_pulse), .st_node(st_node),
      .st_crit(st_crit), .st_errs(st_errs), .st_role(st_role), .err_flag(err_flag)
   );

   function automatic logic [15:0] mk(input logic [9:0] n, input logic c,
                                      input logic [2:0] e, input logic [1:0] r);
      return {n, c, e, r};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] fields();
      return {st_node, st_crit, st_errs, st_role};
   endfunction

   // drive one frame; outputs are sampled on the following falling edge
   task automatic frame(input int slot, input logic [15:0] w);
      @(negedge clk);
      frm_valid = 1'b1;
      frm_slot  = SLOT_W'(slot);
      frm_cycle = CYC_W'(cyc);
      frm_word  = w;
      @(negedge clk);
      frm_valid = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      trig_clear = 1'b1;
      @(negedge clk);
      trig_clear = 1'b0;
   endtask

   task automatic next_cyc();
      cyc = (cyc + 1) % 64;
   endtask

   initial begin
      #500000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] w;
      logic [15:0] held;
      logic [9:0]  ids [3];
      ids[0] = 10'd3; ids[1] = 10'd512; ids[2] = 10'd1023;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pulse", 32'(trig_pulse), 0);
      chk("R1 err", 32'(err_flag), 0);
      chk("R1 fields", 32'(fields()), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R4 R5 sweep: pulse expected when crit or errs > limit
      foreach (ids[k]) begin
         cfg_node = ids[k];
         for (int lim = 0; lim < 8; lim++) begin
            for (int c = 0; c < 2; c++) begin
               for (int e = 0; e < 8; e++) begin
                  cfg_limit = 3'(lim);
                  do_clear();
                  next_cyc();
                  w = mk(ids[k], 1'(c), 3'(e), ROLE);
                  frame(WATCH, w);
                  chk("R4/R5 pulse", 32'(trig_pulse), 32'((c == 1) || (e > lim)));
                  chk("R2 fields", 32'(fields()), 32'(w));
                  @(negedge clk);
                  chk("R10 pulse one cycle", 32'(trig_pulse), 0);
               end
            end
         end
      end
      chk("R9 no spurious err", 32'(err_flag), 0);

      // R6 suppression and re-arm
      cfg_node = 10'd3; cfg_limit = 3'd0;
      do_clear();
      next_cyc(); frame(WATCH, mk(10'd3, 1'b1, 3'd0, ROLE));
      chk("R6 first pulse", 32'(trig_pulse), 1);
      next_cyc(); frame(WATCH, mk(10'd3, 1'b1, 3'd1, ROLE));
      chk("R6 suppressed crit", 32'(trig_pulse), 0);
      next_cyc(); frame(WATCH, mk(10'd3, 1'b0, 3'd7, ROLE));
      chk("R6 suppressed count", 32'(trig_pulse), 0);
      do_clear();
      next_cyc(); frame(WATCH, mk(10'd3, 1'b1, 3'd2, ROLE));
      chk("R6 rearmed pulse", 32'(trig_pulse), 1);
      do_clear();

      // R3 other slot, node mismatch, role mismatch
      held = mk(10'd3, 1'b0, 3'd1, ROLE);
      cfg_limit = 3'd4;
      next_cyc(); frame(WATCH, held);
      next_cyc(); frame(WATCH - 4, mk(10'd3, 1'b1, 3'd5, ROLE));
      chk("R3 other slot no pulse", 32'(trig_pulse), 0);
      chk("R3 other slot fields", 32'(fields()), 32'(held));
      chk("R3 other slot no err", 32'(err_flag), 0);
      frame(WATCH, held);
      next_cyc(); frame(WATCH, mk(10'd2, 1'b1, 3'd6, ROLE));
      chk("R3 node mismatch no pulse", 32'(trig_pulse), 0);
      chk("R3 node mismatch fields", 32'(fields()), 32'(held));
      chk("R8 node mismatch err", 32'(err_flag), 1);
      do_clear();
      chk("R8 err cleared", 32'(err_flag), 0);
      next_cyc(); frame(WATCH, mk(10'd3, 1'b1, 3'd6, 2'b01));
      chk("R3 role mismatch no pulse", 32'(trig_pulse), 0);
      chk("R3 role mismatch fields", 32'(fields()), 32'(held));
      chk("R8 role mismatch err", 32'(err_flag), 1);
      do_clear();

      // R7 duplicate in same cycle ignored
      next_cyc(); frame(WATCH, held);
      frame(WATCH, mk(10'd3, 1'b1, 3'd7, ROLE));
      chk("R7 duplicate no pulse", 32'(trig_pulse), 0);
      chk("R7 duplicate fields", 32'(fields()), 32'(held));
      chk("R7 duplicate no err", 32'(err_flag), 0);

      // R9 skipped slot seen through a later slot
      next_cyc(); frame(WATCH + 5, mk(10'd3, 1'b0, 3'd0, ROLE));
      chk("R9 later slot err", 32'(err_flag), 1);
      next_cyc(); frame(WATCH, held);
      chk("R9 sticky", 32'(err_flag), 1);
      do_clear();
      chk("R9 cleared", 32'(err_flag), 0);

      // R9 cycle ends early, seen at next cycle
      next_cyc(); frame(WATCH - 2, mk(10'd3, 1'b0, 3'd0, ROLE));
      chk("R9 early part no err", 32'(err_flag), 0);
      w = mk(10'd3, 1'b0, 3'd3, ROLE);
      next_cyc(); frame(WATCH, w);
      chk("R9 boundary err", 32'(err_flag), 1);
      chk("R2 accepted after gap", 32'(fields()), 32'(w));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule